// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the address for every beat of a synchronous SRAM access. On any clock edge where either of its two burst-start strobes is high, it captures the external address bus and presents that address on its output one cycle later. After that, each sampled advance strobe moves the two least significant address bits to the next beat of a four-location burst. The upper bits do not change during a burst.

The order of the beats is set by a static mode level. In linear order the low bits count upward and wrap modulo four. In interleaved order the low bits are the loaded low bits XORed with a beat count. Interleaved order is chosen by a low level, so a tie-off at zero, or a floating input that resolves to zero, gives the interleaved order.

Bursts are optional. A start strobe can be asserted on every cycle, and each one loads a fresh address with no dead cycle. The memory array, the write controls and the read data path belong to neighbouring blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `addr_out` becomes all zeros and the beat count returns to zero.
- R2: When `start_a` is sampled high, `addr_out` equals the sampled `addr_in` after that edge.
- R3: When `start_b` is sampled high, alone or together with `start_a`, `addr_out` equals the sampled `addr_in` after that edge.
- R4: A start strobe takes priority over `advance` sampled in the same cycle. Loads on consecutive cycles each take effect on the next edge. A load in the middle of a burst restarts the beat count at zero.
- R5: With `lin_order` = 1, after k sampled advances since a load of low bits L, `addr_out[1:0]` = (L + k) mod 4, and `addr_out[AW-1:2]` equals the loaded upper bits.
- R6: With `lin_order` = 0, after k sampled advances since a load of low bits L, `addr_out[1:0]` = L XOR (k mod 4), and the upper bits equal the loaded upper bits.
- R7: A low level on `lin_order` selects interleaved order. For example, a load of low bits 1 followed by one advance gives low bits 0, not 2.
- R8: When neither start strobe nor `advance` is sampled high, `addr_out` holds its value.
- R9: After four advances, in either order, `addr_out` returns to the loaded address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External address, captured on a start |
| start_a | input | 1 | First burst-start strobe |
| start_b | input | 1 | Second burst-start strobe |
| advance | input | 1 | Step to the next beat of the burst |
| lin_order | input | 1 | Static order select: 1 linear, 0 interleaved |
| addr_out | output | ADDR_W | Current beat address |

## Verification
The hardest case to reach is an advance past the fourth beat, combined with a start strobe that arrives while an advance is also high. From the ports this shows up only as a wrap back to the loaded address, or as a beat count that is not reset. The stimulus sweeps every low-bit start value, every strobe source and both orders. It advances five times per burst, so each burst wraps once. It holds `advance` high during every load and also reloads in the middle of a burst. A stale beat count or a wrong priority therefore shows up in the very next expected address.

// File: rtl/bas_pkg.sv
package bas_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } seq_cmd_e;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    // A start strobe outranks the advance strobe.
    function automatic seq_cmd_e decode_cmd(input logic sa, input logic sb, input logic adv);
        if (sa || sb)
            return CMD_LOAD;
        else if (adv)
            return CMD_STEP;
        else
            return CMD_HOLD;
    endfunction

    // Anything other than a solid high falls through to interleaved.
    function automatic burst_order_e decode_order(input logic lvl);
        if (lvl == 1'b1)
            return ORD_LINEAR;
        else
            return ORD_INTERLEAVE;
    endfunction

endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
    import bas_pkg::*;
(
    input  logic         start_a,
    input  logic         start_b,
    input  logic         advance,
    input  logic         lin_order,
    output seq_cmd_e     cmd,
    output burst_order_e order
);
    always_comb begin
        cmd   = decode_cmd(start_a, start_b, advance);
        order = decode_order(lin_order);
    end
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter
    import bas_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_cmd_e         cmd,
    output logic [LOW_W-1:0] beat_q,
    output logic [LOW_W-1:0] beat_inc
);
    always_comb beat_inc = beat_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else if (cmd == CMD_LOAD)
            beat_q <= '0;
        else if (cmd == CMD_STEP)
            beat_q <= beat_inc;
    end

    assert_beat_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (beat_q == '0));

    assert_beat_step_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (beat_q == LOW_W'($past(beat_q) + 1'b1)));
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
    import bas_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  burst_order_e     order,
    input  logic [LOW_W-1:0] base_lo,
    input  logic [LOW_W-1:0] beat,
    output logic [LOW_W-1:0] low_out
);
    logic [LOW_W-1:0] lin_lo;
    logic [LOW_W-1:0] ilv_lo;

    always_comb lin_lo = base_lo + beat;

    for (genvar b = 0; b < LOW_W; b++) begin : g_ilv
        assign ilv_lo[b] = base_lo[b] ^ beat[b];
    end

    always_comb low_out = (order == ORD_LINEAR) ? lin_lo : ilv_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              start_a,
    input  logic              start_b,
    input  logic              advance,
    input  logic              lin_order,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - LOW_W;

    seq_cmd_e         cmd;
    burst_order_e     order;
    logic [LOW_W-1:0] beat_q;
    logic [LOW_W-1:0] beat_inc;
    logic [LOW_W-1:0] base_lo;
    logic [LOW_W-1:0] next_lo;
    logic [UP_W-1:0]  up_q;
    logic [LOW_W-1:0] lo_q;

    bas_cmd_decode u_dec (
        .start_a  (start_a),
        .start_b  (start_b),
        .advance  (advance),
        .lin_order(lin_order),
        .cmd      (cmd),
        .order    (order)
    );

    bas_beat_counter #(.LOW_W(LOW_W)) u_beat (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .beat_q  (beat_q),
        .beat_inc(beat_inc)
    );

    bas_order_map #(.LOW_W(LOW_W)) u_map (
        .order  (order),
        .base_lo(base_lo),
        .beat   (beat_inc),
        .low_out(next_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q    <= '0;
            lo_q    <= '0;
            base_lo <= '0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    up_q    <= addr_in[ADDR_W-1:LOW_W];
                    lo_q    <= addr_in[LOW_W-1:0];
                    base_lo <= addr_in[LOW_W-1:0];
                end
                CMD_STEP: lo_q <= next_lo;
                default:  ;
            endcase
        end
    end

    assign addr_out = {up_q, lo_q};

    assert_load_a_R2: assert property (@(posedge clk) disable iff (rst)
        start_a |=> (addr_out == $past(addr_in)));

    assert_load_b_R3: assert property (@(posedge clk) disable iff (rst)
        start_b |=> (addr_out == $past(addr_in)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!start_a && !start_b && !advance) |=> $stable(addr_out));

    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        (!start_a && !start_b) |=> (addr_out[ADDR_W-1:LOW_W] == $past(addr_out[ADDR_W-1:LOW_W])));

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!start_a && !start_b && advance && lin_order == 1'b1 && $past(lin_order) == 1'b1)
        |=> (addr_out[LOW_W-1:0] == LOW_W'($past(addr_out[LOW_W-1:0]) + 1'b1)));

    assert_ilv_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!start_a && !start_b && advance && lin_order == 1'b0 && $past(lin_order) == 1'b0)
        |=> ((addr_out[LOW_W-1:0] ^ $past(addr_out[LOW_W-1:0]))
             == ($past(beat_q) ^ LOW_W'($past(beat_q) + 1'b1))));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          start_a, start_b, advance, lin_order;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .LOW_W(LW)) u_burst_addr_seq (
        .clk      (clk),
        .rst      (rst),
        .addr_in  (addr_in),
        .start_a  (start_a),
        .start_b  (start_b),
        .advance  (advance),
        .lin_order(lin_order),
        .addr_out (addr_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [AW-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            fails++;
            $display("FAIL %s addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] base, input int lin, input int k);
        logic [LW-1:0] lo;
        if (lin != 0)
            lo = LW'((int'(base[LW-1:0]) + k) % 4);
        else
            lo = base[LW-1:0] ^ LW'(k % 4);
        return {base[AW-1:LW], lo};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        rst = 1'b1; addr_in = '0; start_a = 0; start_b = 0; advance = 0; lin_order = 0;
        repeat (3) tick();
        check("R1", '0);
        rst = 1'b0;
        tick();
        check("R8", '0);

        // Sweep of order, strobe source and low start bits
        for (int mode = 0; mode < 2; mode++) begin
            for (int src = 0; src < 3; src++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    base = {(AW-LW)'((mode * 12 + src * 4 + lo) * 997 + 5), LW'(lo)};
                    lin_order = mode[0];
                    start_a = (src != 1);
                    start_b = (src != 0);
                    advance = 1'b1;
                    addr_in = base;
                    tick();
                    start_a = 0; start_b = 0;
                    addr_in = ~base;
                    check((src == 0) ? "R2" : "R3", base);
                    for (int k = 1; k <= 5; k++) begin
                        advance = 1'b1;
                        tick();
                        check((mode != 0) ? "R5" : "R6", expect_addr(base, mode, k));
                        if (k == 4) check("R9", base);
                        advance = 1'b0;
                        tick();
                        check("R8", expect_addr(base, mode, k));
                    end
                end
            end
        end

        // R7: low level means interleaved
        lin_order = 1'b0;
        base = {(AW-LW)'(123), 2'd1};
        addr_in = base; start_a = 1; tick();
        start_a = 0; advance = 1; tick();
        advance = 0;
        check("R7", {(AW-LW)'(123), 2'd0});

        // R4: loads every cycle with advance held high
        lin_order = 1'b1;
        advance = 1'b1;
        for (int i = 0; i < 8; i++) begin
            start_b = 1'b1;
            addr_in = AW'(i * 32'h1111 + 3);
            tick();
            check("R4", AW'(i * 32'h1111 + 3));
        end
        start_b = 0;
        tick();
        check("R4", expect_addr(AW'(7 * 32'h1111 + 3), 1, 1));

        // R4: reload in mid burst restarts the beat count
        lin_order = 1'b0;
        base = {(AW-LW)'(77), 2'd3};
        addr_in = base; start_a = 1; advance = 0; tick();
        start_a = 0; advance = 1; tick(); tick();
        check("R6", expect_addr(base, 0, 2));
        base = {(AW-LW)'(91), 2'd2};
        addr_in = base; start_a = 1; tick();
        check("R4", base);
        start_a = 0; tick();
        check("R4", expect_addr(base, 0, 1));
        advance = 0;

        // R1: reset in mid burst
        rst = 1'b1; tick();
        check("R1", '0);
        rst = 1'b0; tick();
        check("R1", '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule